// File: doc/BRIEF.md
# Synchronous Burst Memory with Byte-Lane Writes

This block is a single-port synchronous memory with a built-in four-beat burst address generator. One cycle with the start input high loads a full word address and performs an access there. Each later cycle with the advance input high performs an access at the next address of the burst. Only the two low address bits move during a burst. A mode input picks between a linear sequence (a modulo-4 increment) and an interleaved sequence, where the start bits are XORed with the beat count.

Each access cycle is a read or a write, and the write inputs decide which. A global write strobe writes the whole word. Otherwise a byte-write strobe, together with one select per byte lane, writes any subset of the lanes. The word is 18, 32 or 36 bits wide. The 18- and 36-bit widths use 9-bit lanes that carry a parity bit, and the 32-bit width uses 8-bit lanes. Read data and the data-drive enable come from registers, one clock after the access cycle. A sleep input holds the block in standby. The write controls are active low. For a board-level default, tie the mode input high (interleaved) and the sleep input low (active).

Top module: `sbsram_core`

## Requirements
- R1: A cycle with `start_i` high accesses `addr_i` and records it as the burst base. Every advance access in that burst keeps address bits above bit 1 equal to those of the base.
- R2: With `order_i` low, beat k (k = 0..3) of a burst accesses low bits (base[1:0] + k) mod 4.
- R3: With `order_i` high, beat k of a burst accesses low bits base[1:0] XOR k.
- R4: The fourth advance after a start (the fifth beat) accesses the base address again, and the sequence repeats from there.
- R5: On an access cycle with `wr_all_n` low, all lanes of `din` are stored, whatever `byte_wr_n` and `byte_sel_n` are.
- R6: On an access cycle with `wr_all_n` high and `byte_wr_n` low, lane i (bits i*W to i*W+W-1, where W is 8 for the 32-bit width and 9 otherwise) is stored only if `byte_sel_n[i]` is low. With all selects high, nothing is stored.
- R7: An access cycle with both `wr_all_n` and `byte_wr_n` high is a read. In the next cycle, `dout` holds the full stored word and `dout_oe` is high, whatever the levels of `byte_sel_n`.
- R8: In the cycle after any write access, `dout_oe` is low.
- R9: While `sleep_i` is high, start, advance and write inputs have no effect: nothing is stored, the burst position holds, and `dout_oe` is low in the following cycle.
- R10: After reset, `dout_oe` is low and `dout` is zero.
- R11: In the cycle after a cycle with neither `start_i` nor `adv_i` high, `dout_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Standby request, high ignores all accesses |
| order_i | input | 1 | Burst ordering: 0 linear, 1 interleaved |
| start_i | input | 1 | Load `addr_i` and access it |
| adv_i | input | 1 | Access the next burst address |
| addr_i | input | ADDR_W | Word address loaded on a start cycle |
| wr_all_n | input | 1 | Active-low global write of every lane |
| byte_wr_n | input | 1 | Active-low enable for per-lane writes |
| byte_sel_n | input | LANES | Active-low per-lane write selects |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | High when `dout` should drive the bus |

## Verification
The burst generator is run in both orderings from all four start offsets, for five beats each. Every word in memory holds a value derived from its address, so each returned word shows which address was accessed. Linear and interleaved orders agree from start offsets 0 and 2 and differ from offsets 1 and 3, so the odd offsets tell the two modes apart. The fifth beat shows whether the counter wraps. Lane writes are tried with a partial select pattern, with no selects, and with a global write that overrides byte writes. Sleep is applied in the middle of a burst, which shows whether the burst position moves while asleep.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  // Low two address bits of a burst beat.
  function automatic logic [1:0] beat_lo(input logic [1:0] base_lo,
                                         input logic [1:0] beat,
                                         input logic       interleave);
    logic [1:0] r;
    if (interleave) r = base_lo ^ beat;
    else            r = base_lo + beat;
    return r;
  endfunction

  function automatic int lane_width(input int data_w);
    return (data_w == 32) ? 8 : 9;
  endfunction

endpackage

// File: rtl/sbsram_burst.sv
module sbsram_burst #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              start,
  input  logic              adv,
  input  logic              order,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              access
);
  import sbsram_pkg::*;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  logic [1:0]        beat_nxt;
  logic              load;
  logic              step;

  assign load     = en && start;
  assign step     = en && !start && adv;
  assign beat_nxt = beat_q + 2'd1;
  assign access   = load || step;

  always_comb begin
    if (load) addr_out = addr_in;
    else      addr_out = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], beat_nxt, order)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
    end else if (step) begin
      beat_q <= beat_nxt;
    end
  end

  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
    (step && $past(access)) |-> addr_out[ADDR_W-1:2] == $past(addr_out[ADDR_W-1:2])); // R1
  AST_FIFTH_WRAPS: assert property (@(posedge clk) disable iff (rst)
    (step && beat_q == 2'd3) |-> addr_out[1:0] == base_q[1:0]); // R4

endmodule

// File: rtl/sbsram_wctl.sv
module sbsram_wctl #(
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             access,
  input  logic             wr_all_n,
  input  logic             byte_wr_n,
  input  logic [LANES-1:0] sel_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd
);

  always_comb begin
    lane_we = '0;
    if (access) begin
      if (!wr_all_n)       lane_we = '1;
      else if (!byte_wr_n) lane_we = ~sel_n;
    end
  end

  assign rd = access && wr_all_n && byte_wr_n;

  AST_GLOBAL_ALL: assert property (@(posedge clk) disable iff (rst)
    (access && !wr_all_n) |-> (&lane_we)); // R5
  AST_READ_NO_WE: assert property (@(posedge clk) disable iff (rst)
    rd |-> (lane_we == '0)); // R7
  AST_BYTE_SUBSET: assert property (@(posedge clk) disable iff (rst)
    (access && wr_all_n && !byte_wr_n) |-> ((lane_we & sel_n) == '0)); // R6

endmodule

// File: rtl/sbsram_lane_ram.sv
module sbsram_lane_ram #(
  parameter int LANE_W = 9,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= mem[addr];
  end

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  parameter int LANE_W = sbsram_pkg::lane_width(DATA_W),
  parameter int LANES  = DATA_W / LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              order_i,
  input  logic              start_i,
  input  logic              adv_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_all_n,
  input  logic              byte_wr_n,
  input  logic [LANES-1:0]  byte_sel_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_oe
);

  logic              en;
  logic              access;
  logic [ADDR_W-1:0] acc_addr;
  logic [LANES-1:0]  lane_we;
  logic              rd;

  assign en = !sleep_i && !rst;

  sbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst(rst), .en(en), .start(start_i), .adv(adv_i),
    .order(order_i), .addr_in(addr_i), .addr_out(acc_addr), .access(access)
  );

  sbsram_wctl #(.LANES(LANES)) u_wctl (
    .clk(clk), .rst(rst), .access(access), .wr_all_n(wr_all_n),
    .byte_wr_n(byte_wr_n), .sel_n(byte_sel_n), .lane_we(lane_we), .rd(rd)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    sbsram_lane_ram #(.LANE_W(LANE_W), .ADDR_W(ADDR_W)) u_ram (
      .clk(clk), .rst(rst), .we(lane_we[g]), .rd(rd), .addr(acc_addr),
      .wdata(din[g*LANE_W +: LANE_W]), .rdata(dout[g*LANE_W +: LANE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) dout_oe <= 1'b0;
    else     dout_oe <= rd;
  end

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (|lane_we) |=> !dout_oe); // R8
  AST_SLEEP_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !dout_oe); // R9
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !adv_i) |=> !dout_oe); // R11

endmodule

// File: tb/sim_sbsram_core.sv
module sim_sbsram_core;
  localparam int DW = 36;
  localparam int AW = 6;
  localparam int LW = 9;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_i = 1'b0, order_i = 1'b1, start_i = 1'b0, adv_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic wr_all_n = 1'b1, byte_wr_n = 1'b1;
  logic [NL-1:0] byte_sel_n = '1;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dout;
  logic dout_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] model [1<<AW];

  always #5 clk = ~clk;

  sbsram_core #(.DATA_W(DW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .sleep_i(sleep_i), .order_i(order_i),
    .start_i(start_i), .adv_i(adv_i), .addr_i(addr_i), .wr_all_n(wr_all_n),
    .byte_wr_n(byte_wr_n), .byte_sel_n(byte_sel_n), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  // {order, start[1:0], beat0..beat4 as 2-bit fields, beat0 in the top}
  localparam logic [12:0] VEC [8] = '{
    {1'b0, 2'd0, 10'b00_01_10_11_00},
    {1'b0, 2'd1, 10'b01_10_11_00_01},
    {1'b0, 2'd2, 10'b10_11_00_01_10},
    {1'b0, 2'd3, 10'b11_00_01_10_11},
    {1'b1, 2'd0, 10'b00_01_10_11_00},
    {1'b1, 2'd1, 10'b01_00_11_10_01},
    {1'b1, 2'd2, 10'b10_11_00_01_10},
    {1'b1, 2'd3, 10'b11_10_01_00_11}
  };

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
    return {a, 3'd5, ~a, 3'd2, a, 3'd7, ~a, 3'd1};
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock: apply inputs at the falling edge, return just after the rising edge.
  task automatic cyc(input logic st, input logic ad, input logic [AW-1:0] a,
                     input logic wa, input logic bw, input logic [NL-1:0] sel,
                     input logic [DW-1:0] d, input logic slp, input logic ord);
    @(negedge clk);
    start_i = st; adv_i = ad; addr_i = a; wr_all_n = wa; byte_wr_n = bw;
    byte_sel_n = sel; din = d; sleep_i = slp; order_i = ord;
    @(posedge clk);
    #1;
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic wa, input logic bw,
                             input logic [NL-1:0] sel, input logic [DW-1:0] d);
    for (int i = 0; i < NL; i++)
      if (!wa || (!bw && !sel[i])) model[a][i*LW +: LW] = d[i*LW +: LW];
  endtask

  task automatic rd_check(input string req, input logic [AW-1:0] a);
    cyc(1'b1, 1'b0, a, 1'b1, 1'b1, 4'b0101, '0, 1'b0, 1'b1);
    check({req, " data"}, dout, model[a]);
    check("R7 oe", {35'd0, dout_oe}, 36'd1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 dout", dout, '0);
    check("R10 oe", {35'd0, dout_oe}, '0);
    @(negedge clk);
    rst = 1'b0;

    // Fill memory with address-derived words by global writes.
    for (int a = 0; a < (1<<AW); a++) begin
      cyc(1'b1, 1'b0, AW'(a), 1'b0, 1'b1, '1, pat(AW'(a)), 1'b0, 1'b1);
      model[a] = pat(AW'(a));
    end
    check("R8 oe after write", {35'd0, dout_oe}, '0);

    // Burst orders from every start offset, five beats each.
    for (int v = 0; v < 8; v++) begin
      logic [AW-1:0] base;
      logic [AW-1:0] ea;
      string req;
      base = {AW'(v + 3)} << 2 | AW'(VEC[v][11:10]);
      req = VEC[v][12] ? "R3" : "R2";
      cyc(1'b1, 1'b0, base, 1'b1, 1'b1, '1, '0, 1'b0, VEC[v][12]);
      ea = {base[AW-1:2], VEC[v][9:8]};
      check({req, " R1 beat0"}, dout, model[ea]);
      for (int k = 1; k < 5; k++) begin
        cyc(1'b0, 1'b1, '0, 1'b1, 1'b1, '1, '0, 1'b0, VEC[v][12]);
        ea = {base[AW-1:2], VEC[v][9-2*k -: 2]};
        check(k == 4 ? "R4 wrap" : {req, " R1 beat"}, dout, model[ea]);
        check("R7 oe in burst", {35'd0, dout_oe}, 36'd1);
      end
    end

    // Lane writes: lanes 0 and 2 only.
    cyc(1'b1, 1'b0, 6'd10, 1'b1, 1'b0, 4'b1010, 36'hFFFFFFFFF, 1'b0, 1'b1);
    model_write(6'd10, 1'b1, 1'b0, 4'b1010, 36'hFFFFFFFFF);
    check("R8 oe after byte write", {35'd0, dout_oe}, '0);
    rd_check("R6 partial lanes", 6'd10);

    // Byte write with no lane selected stores nothing.
    cyc(1'b1, 1'b0, 6'd11, 1'b1, 1'b0, 4'b1111, '0, 1'b0, 1'b1);
    rd_check("R6 no lanes", 6'd11);

    // Global write overrides the byte controls.
    cyc(1'b1, 1'b0, 6'd12, 1'b0, 1'b0, 4'b1111, 36'h123456789, 1'b0, 1'b1);
    model_write(6'd12, 1'b0, 1'b0, 4'b1111, 36'h123456789);
    rd_check("R5 global override", 6'd12);

    // Idle cycle: no drive.
    cyc(1'b0, 1'b0, '0, 1'b1, 1'b1, '1, '0, 1'b0, 1'b1);
    check("R11 idle oe", {35'd0, dout_oe}, '0);

    // Sleep ignores writes and reads.
    cyc(1'b1, 1'b0, 6'd12, 1'b0, 1'b1, '1, '0, 1'b1, 1'b1);
    check("R9 sleep write oe", {35'd0, dout_oe}, '0);
    cyc(1'b1, 1'b0, 6'd12, 1'b1, 1'b1, '1, '0, 1'b1, 1'b1);
    check("R9 sleep read oe", {35'd0, dout_oe}, '0);
    rd_check("R9 data kept", 6'd12);

    // Sleep in mid-burst holds the burst position (interleaved from 01).
    cyc(1'b1, 1'b0, 6'h21, 1'b1, 1'b1, '1, '0, 1'b0, 1'b1);
    check("R3 beat0", dout, model[6'h21]);
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b1, '1, '0, 1'b0, 1'b1);
    check("R3 beat1", dout, model[6'h20]);
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b1, '1, '0, 1'b1, 1'b1);
    check("R9 sleep adv oe", {35'd0, dout_oe}, '0);
    cyc(1'b0, 1'b1, '0, 1'b1, 1'b1, '1, '0, 1'b0, 1'b1);
    check("R9 burst held", dout, model[6'h23]);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule